// File: doc/BRIEF.md
# Serial Register-File Slave with Broadcast Writes

This block is a serial slave that exposes a byte-wide register file through a four-wire link: an active-low select, a serial clock, a data input and a data output with its own output-enable. A transfer opens when the select falls. The first sixteen serial bits form a header: a direction flag and a fifteen-bit address. Data bytes follow the header. The serial pins are brought into the system clock domain and edge-detected there, so the register file is written and read entirely on the system clock.

A device answers a normal access only when its two-bit strapped chip address matches two bits of the header. A write sends any number of bytes. After each whole byte the target offset steps by one, until the select rises. A special address prefix turns a write into a broadcast that every device on the shared bus accepts. Since the strap is two bits wide, at most four devices take part. A read returns one byte on the serial output while the output-enable is high.

Top module: `spi_rf_slave`

## Requirements
- R1: A frame sends header bit 15 first. Bit 15 is the direction (1 = read, 0 = write), and bits 14..0 are address A14..A0, sent MSB first. Data bytes follow, each sent MSB first. Inputs are taken on rising serial-clock edges.
- R2: A write whose A14:A13 = 2'b00 and whose A12:A11 equal `chip_addr` stores the first data byte at offset A10:A0.
- R3: Each further whole byte in the same select window goes to the previous offset plus one. The offset wraps from 11'h7FF to 11'h000. There is no limit on the number of bytes.
- R4: If the select rises before the eighth bit of a data byte, the partial byte is dropped and no register changes.
- R5: A write with A14:A11 = 4'b0001 is a broadcast, and every device accepts it whatever its `chip_addr`. A read with the same prefix is an ordinary access and only the device with `chip_addr` = 2'b01 answers it.
- R6: An access whose chip bits do not select the device, or whose A14:A13 is not 2'b00 outside a broadcast write, changes no register and leaves `sdo_oe` low.
- R7: For a selected read, `sdo_oe` is high for the data phase. The addressed byte leaves on `sdo` MSB first, and each bit changes after a falling serial-clock edge. `sdi` in the data phase writes nothing.
- R8: `sdo_oe` is low while the select is high and during every write frame.
- R9: Offsets at or above `NUM_REGS` read as 8'h00, and writes to them are dropped.
- R10: After reset every register holds 8'h00 and `sdo_oe` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_addr | input | 2 | Strapped device address compared with A12:A11 |
| csb | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial read data out |
| sdo_oe | output | 1 | High when `sdo` should be driven onto the bus |

## Verification
Four devices with different straps share one bus, so every frame is checked for wrong selection as well as for data. A burst that crosses the end of the implemented space and one that wraps past 11'h7FF would expose a design that stops stepping, fails to wrap or stores past the array. A frame cut off inside a byte checks that a partial byte is dropped rather than written with stale bits. A read that uses the broadcast prefix checks that the prefix is honoured only for writes, which a careless decoder would get wrong by driving four outputs at once.

// File: rtl/spi_rf_pkg.sv
package spi_rf_pkg;

    localparam int ADDR_W  = 15;
    localparam int OFS_W   = 11;
    localparam int DATA_W  = 8;
    localparam int HDR_W   = ADDR_W + 1;
    localparam int CNT_W   = $clog2(HDR_W);
    localparam logic [3:0] BCAST_PREFIX = 4'b0001;

    typedef enum logic [1:0] {
        PH_HDR,
        PH_WR,
        PH_RD,
        PH_SKIP
    } phase_t;

    typedef struct packed {
        logic              rd;
        logic [ADDR_W-1:0] addr;
    } hdr_t;

    typedef struct packed {
        logic csb;
        logic sclk;
        logic sdi;
    } pins_t;

    typedef struct packed {
        logic             sel;
        logic [OFS_W-1:0] ofs;
    } decode_t;

    function automatic decode_t decode_hdr(hdr_t h, logic [1:0] chip);
        decode_t d;
        logic    bcast;
        bcast = !h.rd && (h.addr[14:11] == BCAST_PREFIX);
        d.sel = bcast || (h.addr[14:13] == 2'b00 && h.addr[12:11] == chip);
        d.ofs = h.addr[OFS_W-1:0];
        return d;
    endfunction

endpackage

// File: rtl/spi_rf_pins.sv
module spi_rf_pins
    import spi_rf_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic csb,
    input  logic sclk,
    input  logic sdi,
    output logic cs_idle,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic sdi_bit
);

    localparam pins_t IDLE_PINS = '{csb: 1'b1, sclk: 1'b0, sdi: 1'b0};

    pins_t chain [STAGES];
    logic  sclk_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= IDLE_PINS;
            sclk_prev <= 1'b0;
        end else begin
            chain[0] <= '{csb: csb, sclk: sclk, sdi: sdi};
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
            sclk_prev <= chain[STAGES-1].sclk;
        end
    end

    assign cs_idle   = chain[STAGES-1].csb;
    assign sdi_bit   = chain[STAGES-1].sdi;
    assign sclk_rise = chain[STAGES-1].sclk & ~sclk_prev;
    assign sclk_fall = ~chain[STAGES-1].sclk & sclk_prev;

endmodule

// File: rtl/spi_rf_frame.sv
module spi_rf_frame
    import spi_rf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_idle,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              sdi_bit,
    input  logic [1:0]        chip_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic [OFS_W-1:0]  rd_ofs,
    output logic              we,
    output logic [OFS_W-1:0]  wofs,
    output logic [DATA_W-1:0] wdata,
    output logic              sdo,
    output logic              sdo_oe
);

    phase_t              phase;
    logic [CNT_W-1:0]    cnt;
    logic [HDR_W-2:0]    hsh;
    logic [DATA_W-2:0]   rx;
    logic [DATA_W-1:0]   tx;
    logic [OFS_W-1:0]    ofs;
    hdr_t                hdr_now;
    decode_t             dec;
    logic [DATA_W-1:0]   byte_now;

    assign hdr_now  = hdr_t'({hsh, sdi_bit});
    assign dec      = decode_hdr(hdr_now, chip_addr);
    assign rd_ofs   = dec.ofs;
    assign byte_now = {rx, sdi_bit};

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_HDR;
            cnt   <= '0;
            hsh   <= '0;
            rx    <= '0;
            tx    <= '0;
            ofs   <= '0;
            we    <= 1'b0;
            wofs  <= '0;
            wdata <= '0;
            sdo   <= 1'b0;
        end else begin
            we <= 1'b0;
            if (cs_idle) begin
                phase <= PH_HDR;
                cnt   <= '0;
            end else begin
                if (sclk_rise) begin
                    unique case (phase)
                        PH_HDR: begin
                            hsh <= hdr_now[HDR_W-2:0];
                            if (cnt == CNT_W'(HDR_W - 1)) begin
                                cnt <= '0;
                                ofs <= dec.ofs;
                                tx  <= rd_data;
                                if (!dec.sel)        phase <= PH_SKIP;
                                else if (hdr_now.rd) phase <= PH_RD;
                                else                 phase <= PH_WR;
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end
                        PH_WR: begin
                            rx <= byte_now[DATA_W-2:0];
                            if (cnt == CNT_W'(DATA_W - 1)) begin
                                cnt   <= '0;
                                we    <= 1'b1;
                                wofs  <= ofs;
                                wdata <= byte_now;
                                ofs   <= ofs + 1'b1;
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end
                        default: ;
                    endcase
                end
                if (sclk_fall && phase == PH_RD) begin
                    sdo <= tx[DATA_W-1];
                    tx  <= {tx[DATA_W-2:0], 1'b0};
                end
            end
        end
    end

    assign sdo_oe = (phase == PH_RD);

endmodule

// File: rtl/spi_rf_regfile.sv
module spi_rf_regfile
    import spi_rf_pkg::*;
#(
    parameter int NUM_REGS = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [OFS_W-1:0]  wofs,
    input  logic [DATA_W-1:0] wdata,
    input  logic [OFS_W-1:0]  rofs,
    output logic [DATA_W-1:0] rdata
);

    localparam int               IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam logic [OFS_W:0]   LIMIT = (OFS_W + 1)'(NUM_REGS);

    logic [DATA_W-1:0] mem [NUM_REGS];
    logic              w_in_range;
    logic              r_in_range;

    assign w_in_range = {1'b0, wofs} < LIMIT;
    assign r_in_range = {1'b0, rofs} < LIMIT;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_REGS; i++) mem[i] <= '0;
        end else if (we && w_in_range) begin
            mem[wofs[IDX_W-1:0]] <= wdata;
        end
    end

    assign rdata = r_in_range ? mem[rofs[IDX_W-1:0]] : '0;

endmodule

// File: rtl/spi_rf_slave.sv
module spi_rf_slave
    import spi_rf_pkg::*;
#(
    parameter int NUM_REGS    = 1024,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] chip_addr,
    input  logic       csb,
    input  logic       sclk,
    input  logic       sdi,
    output logic       sdo,
    output logic       sdo_oe
);

    logic              cs_idle;
    logic              sclk_rise;
    logic              sclk_fall;
    logic              sdi_bit;
    logic              we;
    logic [OFS_W-1:0]  wofs;
    logic [OFS_W-1:0]  rofs;
    logic [DATA_W-1:0] wdata;
    logic [DATA_W-1:0] rdata;

    spi_rf_pins #(.STAGES(SYNC_STAGES)) u_pins (
        .clk       (clk),
        .rst       (rst),
        .csb       (csb),
        .sclk      (sclk),
        .sdi       (sdi),
        .cs_idle   (cs_idle),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .sdi_bit   (sdi_bit)
    );

    spi_rf_frame u_frame (
        .clk       (clk),
        .rst       (rst),
        .cs_idle   (cs_idle),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .sdi_bit   (sdi_bit),
        .chip_addr (chip_addr),
        .rd_data   (rdata),
        .rd_ofs    (rofs),
        .we        (we),
        .wofs      (wofs),
        .wdata     (wdata),
        .sdo       (sdo),
        .sdo_oe    (sdo_oe)
    );

    spi_rf_regfile #(.NUM_REGS(NUM_REGS)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (we),
        .wofs  (wofs),
        .wdata (wdata),
        .rofs  (rofs),
        .rdata (rdata)
    );

endmodule

// File: rtl/spi_rf_slave_chk.sv
module spi_rf_slave_chk
    import spi_rf_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             cs_idle,
    input logic             sclk_fall,
    input logic             we,
    input logic [OFS_W-1:0] wofs,
    input logic             sdo,
    input logic             sdo_oe
);

    logic             run_valid;
    logic [OFS_W-1:0] run_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_valid <= 1'b0;
            run_last  <= '0;
        end else if (we) begin
            run_valid <= 1'b1;
            run_last  <= wofs;
        end else if (cs_idle) begin
            run_valid <= 1'b0;
        end
    end

    // R8: output enable drops once the synchronised select has been seen high
    assert_oe_clears_R8: assert property (@(posedge clk) disable iff (rst)
        $past(cs_idle) |-> !sdo_oe);

    // R7: a read frame never writes the register file
    assert_no_write_in_read_R7: assert property (@(posedge clk) disable iff (rst)
        sdo_oe |-> !we);

    // R7: serial output only moves after a falling serial-clock edge
    assert_sdo_on_fall_R7: assert property (@(posedge clk) disable iff (rst)
        !$stable(sdo) |-> $past(sclk_fall));

    // R3: consecutive writes in one window step the offset by one
    assert_burst_step_R3: assert property (@(posedge clk) disable iff (rst)
        (we && run_valid) |-> (wofs == run_last + 1'b1));

    // R2: each byte produces a single write strobe
    assert_we_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        we |=> !we);

endmodule

bind spi_rf_slave spi_rf_slave_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cs_idle   (cs_idle),
    .sclk_fall (sclk_fall),
    .we        (we),
    .wofs      (wofs),
    .sdo       (sdo),
    .sdo_oe    (sdo_oe)
);

// File: tb/spi_rf_slave_tb.sv
`timescale 1ns/1ps
module spi_rf_slave_tb;

    localparam int NREG = 256;
    localparam int NDEV = 4;
    localparam int HP   = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic csb = 1'b1;
    logic sclk = 1'b0;
    logic sdi = 1'b0;
    logic [NDEV-1:0] sdo_w;
    logic [NDEV-1:0] oe_w;

    int checks = 0;
    int fails = 0;
    int idle_cnt = 0;
    bit done = 1'b0;

    logic [7:0] model [NDEV][NREG];

    always #4 clk = ~clk;

    for (genvar g = 0; g < NDEV; g++) begin : g_dev
        spi_rf_slave #(.NUM_REGS(NREG)) u_dut (
            .clk       (clk),
            .rst       (rst),
            .chip_addr (2'(g)),
            .csb       (csb),
            .sclk      (sclk),
            .sdi       (sdi),
            .sdo       (sdo_w[g]),
            .sdo_oe    (oe_w[g])
        );
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit selected(input int dev, input bit rd, input logic [14:0] a);
        bit bc;
        bc = !rd && (a[14:11] == 4'b0001);
        return bc || (a[14:13] == 2'b00 && a[12:11] == 2'(dev));
    endfunction

    function automatic logic [7:0] expect_rd(input int dev, input logic [10:0] o);
        return (int'(o) < NREG) ? model[dev][int'(o)] : 8'h00;
    endfunction

    function automatic logic [14:0] adr(input int dev, input logic [10:0] o);
        return {2'b00, 2'(dev), o};
    endfunction

    // R8 per-clock monitor: select high for a while means no output enable
    always @(negedge clk) begin
        if (rst || !csb) idle_cnt <= 0;
        else begin
            idle_cnt <= idle_cnt + 1;
            if (idle_cnt > 4 && oe_w != '0)
                check(1'b0, "R8", "oe while idle", 32'(oe_w), 0);
        end
    end

    task automatic bit_cycle(input logic b, output logic [NDEV-1:0] so, output logic [NDEV-1:0] oe);
        sdi = b;
        repeat (HP) @(negedge clk);
        so = sdo_w;
        oe = oe_w;
        sclk = 1'b1;
        repeat (HP) @(negedge clk);
        sclk = 1'b0;
    endtask

    task automatic frame(input bit rd, input logic [14:0] a, input int nb,
                         input logic [7:0] d0, input logic [7:0] d1,
                         input logic [7:0] d2, input logic [7:0] d3,
                         input int tail, input string req);
        logic [NDEV-1:0] so, oe;
        logic [15:0] hdr;
        logic [7:0] dat [4];
        logic [7:0] got [NDEV];
        logic [10:0] o;
        dat[0] = d0; dat[1] = d1; dat[2] = d2; dat[3] = d3;
        hdr = {rd, a};
        o = a[10:0];
        @(negedge clk);
        csb = 1'b0;
        repeat (HP) @(negedge clk);
        for (int i = 15; i >= 0; i--) bit_cycle(hdr[i], so, oe);
        if (rd) begin
            for (int d = 0; d < NDEV; d++) got[d] = '0;
            for (int i = 0; i < 8; i++) begin
                bit_cycle(1'b1, so, oe);
                for (int d = 0; d < NDEV; d++) begin
                    got[d] = {got[d][6:0], so[d]};
                    check(oe[d] == selected(d, 1'b1, a), req, $sformatf("read oe dev%0d", d),
                          32'(oe[d]), 32'(selected(d, 1'b1, a)));
                end
            end
            for (int d = 0; d < NDEV; d++)
                if (selected(d, 1'b1, a))
                    check(got[d] == expect_rd(d, o), req,
                          $sformatf("read data dev%0d ofs %0h", d, o),
                          32'(got[d]), 32'(expect_rd(d, o)));
        end else begin
            for (int k = 0; k < nb; k++) begin
                for (int i = 7; i >= 0; i--) bit_cycle(dat[k][i], so, oe);
                check(oe == '0, "R8", "oe during write", 32'(oe), 0);
            end
            for (int i = 0; i < tail; i++) bit_cycle(1'b1, so, oe);
        end
        repeat (HP) @(negedge clk);
        csb = 1'b1;
        repeat (3 * HP) @(negedge clk);
        if (!rd) begin
            for (int d = 0; d < NDEV; d++) begin
                if (selected(d, 1'b0, a)) begin
                    logic [10:0] p;
                    p = o;
                    for (int k = 0; k < nb; k++) begin
                        if (int'(p) < NREG) model[d][int'(p)] = dat[k];
                        p = p + 11'd1;
                    end
                end
            end
        end
    endtask

    task automatic rd(input logic [14:0] a, input string req);
        frame(1'b1, a, 0, 8'h0, 8'h0, 8'h0, 8'h0, 0, req);
    endtask

    initial begin
        for (int d = 0; d < NDEV; d++)
            for (int r = 0; r < NREG; r++) model[d][r] = 8'h00;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);

        // R10: reset state
        check(oe_w == '0, "R10", "oe after reset", 32'(oe_w), 0);
        rd(adr(0, 11'h005), "R10");

        // R1 R2 R7: single write then read, neighbours untouched
        frame(1'b0, adr(1, 11'h005), 1, 8'hA5, 8'h0, 8'h0, 8'h0, 0, "R2");
        rd(adr(1, 11'h005), "R1");
        rd(adr(0, 11'h005), "R2");
        rd(adr(1, 11'h005), "R7");

        // R3: burst of four bytes
        frame(1'b0, adr(2, 11'h010), 4, 8'h11, 8'h22, 8'h33, 8'h44, 0, "R3");
        for (int k = 0; k < 4; k++) rd(adr(2, 11'h010 + 11'(k)), "R3");

        // R3 R9: burst running past the implemented space, then wrapping
        frame(1'b0, adr(3, 11'h0FE), 3, 8'h5A, 8'h6B, 8'h7C, 8'h0, 0, "R9");
        rd(adr(3, 11'h0FF), "R3");
        rd(adr(3, 11'h100), "R9");
        frame(1'b0, adr(3, 11'h7FF), 2, 8'h99, 8'h88, 8'h0, 8'h0, 0, "R3");
        rd(adr(3, 11'h000), "R3");
        rd(adr(3, 11'h7FF), "R9");

        // R4: partial byte dropped
        frame(1'b0, adr(0, 11'h021), 1, 8'h77, 8'h0, 8'h0, 8'h0, 0, "R4");
        frame(1'b0, adr(0, 11'h020), 1, 8'hC3, 8'h0, 8'h0, 8'h0, 5, "R4");
        rd(adr(0, 11'h020), "R4");
        rd(adr(0, 11'h021), "R4");

        // R5: broadcast write reaches every strap
        frame(1'b0, {4'b0001, 11'h030}, 2, 8'h3C, 8'h4D, 8'h0, 8'h0, 0, "R5");
        for (int d = 0; d < NDEV; d++) begin
            rd(adr(d, 11'h030), "R5");
            rd(adr(d, 11'h031), "R5");
        end
        // R5: prefix on a read only selects strap 01
        rd({4'b0001, 11'h030}, "R5");

        // R6: non-matching accesses ignored
        frame(1'b0, {2'b10, 2'b01, 11'h030}, 1, 8'hFF, 8'h0, 8'h0, 8'h0, 0, "R6");
        rd(adr(1, 11'h030), "R6");
        frame(1'b0, adr(2, 11'h005), 1, 8'hE1, 8'h0, 8'h0, 8'h0, 0, "R6");
        rd(adr(1, 11'h005), "R6");
        rd(adr(2, 11'h005), "R6");
        rd({2'b01, 2'b00, 11'h005}, "R6");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R10 watchdog act=timeout exp=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule